// File: doc/BRIEF.md
# SPI Flash Software-Transaction Engine

This block lets firmware run one transaction at a time on a single-lane SPI flash bus. Firmware first writes a command byte, an optional three-byte address and up to four data bytes into a small byte-wide register file. It then writes a control byte whose top bit starts the engine. The engine selects one of four flash devices and sends the command byte. Next it sends the address, if enabled. In the data phase it either shifts out the write bytes or captures read bytes into the data registers. When the transaction is over it clears the start bit, and firmware polls that bit to learn the transaction is done.

The serial clock runs at half the register clock, so there is no divider. A separate select-hold register can keep any chip select low between transactions. This lets one flash command span several back-to-back hardware transactions, for example a long dummy phase split across two runs.

Top module: `sfl_uma_engine`

## Requirements
- R1: After reset the control register reads 0x00, the select-hold register reads 0x0F, all four chip selects are high and SCK is low.
- R2: A write of the control register with bit 7 set starts a transaction. Bit 7 then reads 1 until the engine clears it. The clear is visible exactly 16*N+3 clock edges after the starting write edge, where N = 1 + (3 if address enabled) + the effective data count.
- R3: Register offsets are fixed as follows:
  - 0x0: command byte.
  - 0x1, 0x2, 0x3: address low, middle and high bytes.
  - 0x4 to 0x7: data bytes 0 to 3.
  - 0x8: control.
  - 0x9: select hold.

  The control fields are:
  - bits 2:0: data count.
  - bit 3: address enable.
  - bit 4: write (1) or read (0).
  - bits 6:5: device select.
  - bit 7: start/busy.

  Every field except bit 7 reads back as written.
- R4: The command byte is sent first. When bit 3 is set, the address follows as high, middle, then low byte. Every byte goes out MSB first in SPI mode 0: SCK idles low, MOSI changes only while SCK is low, and MISO is sampled on the rising SCK edge.
- R5: In a write transaction, data bytes 0 upward are sent after the address. The data registers keep their contents.
- R6: In a read transaction, MOSI is 0 during the data phase. The received bytes land in data registers 0 upward in arrival order, and data registers beyond the count stay unchanged.
- R7: A data count of 5, 6 or 7 is treated as 4.
- R8: During a transaction, the select picked by bits 6:5 is low. With the hold register at 0x0F, exactly one select is low during the transaction and none is low after it.
- R9: A 0 in bit i of the hold register keeps select i low whether or not a transaction is running, including between transactions. Writing 1 releases it.
- R10: While bit 7 reads 1, writes to every register (command, address, data, control, hold) are ignored.
- R11: A transaction produces exactly 8*N rising SCK edges, and SCK toggles every clock cycle during the shift phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and shift clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for the register at reg_addr (combinational) |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 4 | Active-low chip selects |

## Verification
The busy bit is due to clear 16*N+3 edges after the starting write. The bench counts edges from that write and samples the control register half a cycle after each edge, so the count must match exactly. The select pattern is checked after edge 5, by which point the shift phase has begun. The bench's flash model samples MOSI half a cycle after each rising SCK and shifts MISO at the same point, so captured read data, the MOSI stream and the rising-edge count are all compared only after busy has cleared. Register contents and select levels are read back at falling clock edges, never at the active edge.

// File: rtl/sfl_uma_pkg.sv
// Shared types for the SPI flash software-transaction engine.
// Assumes the control byte layout is fixed by software: count, address enable,
// direction, select, start (LSB to MSB).
package sfl_uma_pkg;

    typedef struct packed {
        logic       go;     // bit 7: start / busy
        logic [1:0] sel;    // bits 6:5: device select
        logic       wr;     // bit 4: write data phase
        logic       aen;    // bit 3: address phase enable
        logic [2:0] cnt;    // bits 2:0: data byte count
    } uma_ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_SHIFT  = 2'd2,
        ST_FINISH = 2'd3
    } seq_state_t;

endpackage

// File: rtl/sfl_uma_regs.sv
// Byte-wide register file: command, address bytes, data bytes, control and
// select-hold. Assumes one access per cycle; all writes are blocked while the
// start bit is set. The sequencer returns read bytes and a done pulse.
module sfl_uma_regs
    import sfl_uma_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int DATA_BYTES = 4,
    parameter int NUM_CS     = 4,
    parameter int DSEL_W     = $clog2(DATA_BYTES)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             reg_wr,
    input  logic [3:0]                       reg_addr,
    input  logic [7:0]                       reg_wdata,
    output logic [7:0]                       reg_rdata,
    input  logic                             done,
    input  logic                             rx_we,
    input  logic [DSEL_W-1:0]                rx_idx,
    input  logic [7:0]                       rx_byte,
    output logic [7:0]                       opcode_q,
    output logic [ADDR_BYTES-1:0][7:0]       addr_q,
    output logic [DATA_BYTES-1:0][7:0]       data_q,
    output uma_ctrl_t                        ctrl_q,
    output logic [NUM_CS-1:0]                hold_q
);

    localparam logic [3:0] OFF_OPC  = 4'd0;
    localparam logic [3:0] OFF_ADDR = 4'd1;
    localparam logic [3:0] OFF_DATA = 4'(1 + ADDR_BYTES);
    localparam logic [3:0] OFF_CTRL = 4'(1 + ADDR_BYTES + DATA_BYTES);
    localparam logic [3:0] OFF_HOLD = 4'(2 + ADDR_BYTES + DATA_BYTES);

    logic wr_ok;
    assign wr_ok = reg_wr && !ctrl_q.go;

    // Register update: software writes when idle, busy clear and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode_q <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            ctrl_q   <= '0;
            hold_q   <= '1;
        end else begin
            if (done)
                ctrl_q.go <= 1'b0;
            if (wr_ok) begin
                if (reg_addr == OFF_OPC)
                    opcode_q <= reg_wdata;
                for (int i = 0; i < ADDR_BYTES; i++)
                    if (reg_addr == OFF_ADDR + 4'(i))
                        addr_q[i] <= reg_wdata;
                for (int i = 0; i < DATA_BYTES; i++)
                    if (reg_addr == OFF_DATA + 4'(i))
                        data_q[i] <= reg_wdata;
                if (reg_addr == OFF_CTRL)
                    ctrl_q <= uma_ctrl_t'(reg_wdata);
                if (reg_addr == OFF_HOLD)
                    hold_q <= reg_wdata[NUM_CS-1:0];
            end
            if (rx_we)
                data_q[rx_idx] <= rx_byte;
        end
    end

    // Read mux: combinational view of the register at reg_addr.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFF_OPC)
            reg_rdata = opcode_q;
        for (int i = 0; i < ADDR_BYTES; i++)
            if (reg_addr == OFF_ADDR + 4'(i))
                reg_rdata = addr_q[i];
        for (int i = 0; i < DATA_BYTES; i++)
            if (reg_addr == OFF_DATA + 4'(i))
                reg_rdata = data_q[i];
        if (reg_addr == OFF_CTRL)
            reg_rdata = ctrl_q;
        if (reg_addr == OFF_HOLD)
            reg_rdata = 8'(hold_q);
    end

    // R2: the done pulse from the sequencer clears the busy bit on the next edge.
    p_busy_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !ctrl_q.go);

    // R10: writes while busy leave the registers unchanged.
    p_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.go && reg_wr) |=> ($stable(opcode_q) && $stable(hold_q) && $stable(addr_q)));

endmodule

// File: rtl/sfl_uma_seq.sv
// Transfer sequencer: walks the command, address and data bytes, produces a
// half-rate mode-0 SCK, drives MOSI MSB first and captures MISO on rising SCK.
// Assumes the control fields stay stable while busy (the register file enforces it).
module sfl_uma_seq
    import sfl_uma_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int DATA_BYTES = 4,
    parameter int DSEL_W     = $clog2(DATA_BYTES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       busy,
    input  logic [2:0]                 cnt,
    input  logic                       aen,
    input  logic                       wr,
    input  logic [7:0]                 opcode_q,
    input  logic [ADDR_BYTES-1:0][7:0] addr_q,
    input  logic [DATA_BYTES-1:0][7:0] data_q,
    input  logic                       spi_miso,
    output logic                       spi_sck,
    output logic                       spi_mosi,
    output logic                       active,
    output logic                       done,
    output logic                       rx_we,
    output logic [DSEL_W-1:0]          rx_idx,
    output logic [7:0]                 rx_byte
);

    localparam int TOT_W  = $clog2(1 + ADDR_BYTES + DATA_BYTES + 1);
    localparam int ASEL_W = $clog2(ADDR_BYTES);

    seq_state_t         state;
    logic [TOT_W-1:0]   byte_idx;
    logic [2:0]         bit_idx;
    logic               sck_q;
    logic [7:0]         rx_sh;

    logic [2:0]         cnt_eff;
    logic [TOT_W-1:0]   pre_len;
    logic [TOT_W-1:0]   n_bytes;
    logic               is_data;
    logic [DSEL_W-1:0]  data_idx;
    logic [ASEL_W-1:0]  addr_idx;
    logic [7:0]         cur_byte;

    // Byte plan: clamp count, prefix length and total length.
    always_comb begin
        cnt_eff  = (cnt > 3'(DATA_BYTES)) ? 3'(DATA_BYTES) : cnt;
        pre_len  = aen ? TOT_W'(1 + ADDR_BYTES) : TOT_W'(1);
        n_bytes  = pre_len + TOT_W'(cnt_eff);
        is_data  = (byte_idx >= pre_len);
        data_idx = DSEL_W'(byte_idx - pre_len);
        addr_idx = ASEL_W'(TOT_W'(ADDR_BYTES) - byte_idx);
    end

    // Byte select: command, then address high to low, then data or zero fill.
    always_comb begin
        if (byte_idx == '0)
            cur_byte = opcode_q;
        else if (!is_data)
            cur_byte = addr_q[addr_idx];
        else if (wr)
            cur_byte = data_q[data_idx];
        else
            cur_byte = 8'h00;
    end

    // Sequencer state, bit/byte counters, SCK phase and MISO capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            byte_idx <= '0;
            bit_idx  <= '0;
            sck_q    <= 1'b0;
            rx_sh    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    byte_idx <= '0;
                    bit_idx  <= '0;
                    sck_q    <= 1'b0;
                    if (busy)
                        state <= ST_SETUP;
                end
                ST_SETUP: state <= ST_SHIFT;
                ST_SHIFT: begin
                    if (!sck_q) begin
                        sck_q <= 1'b1;
                        rx_sh <= {rx_sh[6:0], spi_miso};
                    end else begin
                        sck_q   <= 1'b0;
                        bit_idx <= bit_idx + 3'd1;
                        if (bit_idx == 3'd7) begin
                            if (byte_idx == n_bytes - TOT_W'(1))
                                state <= ST_FINISH;
                            else
                                byte_idx <= byte_idx + TOT_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign spi_sck  = sck_q;
    assign spi_mosi = (state == ST_SHIFT) ? cur_byte[3'd7 - bit_idx] : 1'b0;
    assign active   = (state != ST_IDLE);
    assign done     = (state == ST_FINISH);
    assign rx_we    = (state == ST_SHIFT) && sck_q && (bit_idx == 3'd7) && is_data && !wr;
    assign rx_idx   = data_idx;
    assign rx_byte  = rx_sh;

    // R4: SCK is low outside the shift phase (mode 0 idle level).
    p_sck_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SHIFT) |-> !spi_sck);

    // R11: SCK toggles on every cycle of the shift phase.
    p_sck_toggle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SHIFT) && ($past(state) == ST_SHIFT)) |-> (spi_sck != $past(spi_sck)));

    // R2: the finish state is only reached from the shift phase.
    p_finish_after_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH) |-> ($past(state) == ST_SHIFT));

endmodule

// File: rtl/sfl_uma_csel.sv
// Chip-select decode: a select is low when the running transaction picks it
// or when its hold bit is 0. Assumes hold bits are active-low.
module sfl_uma_csel #(
    parameter int NUM_CS = 4,
    parameter int SEL_W  = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [SEL_W-1:0]  sel,
    input  logic [NUM_CS-1:0] hold_q,
    output logic [NUM_CS-1:0] spi_cs_n
);

    // One decoder per select line.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign spi_cs_n[g] = ~((active && (sel == SEL_W'(g))) || !hold_q[g]);
    end

    // R8: with no hold bit active, at most one select is low.
    p_single_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (&hold_q) |-> $onehot0(~spi_cs_n));

endmodule

// File: rtl/sfl_uma_engine.sv
// Top of the SPI flash software-transaction engine: register file, transfer
// sequencer and chip-select decode. Assumes a single-lane, single-rate flash bus
// clocked at half the register clock.
module sfl_uma_engine
    import sfl_uma_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int DATA_BYTES = 4,
    parameter int NUM_CS     = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        spi_sck,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic [3:0]  spi_cs_n
);

    localparam int DSEL_W = $clog2(DATA_BYTES);
    localparam int SEL_W  = $clog2(NUM_CS);

    logic [7:0]                 opcode_q;
    logic [ADDR_BYTES-1:0][7:0] addr_q;
    logic [DATA_BYTES-1:0][7:0] data_q;
    uma_ctrl_t                  ctrl_q;
    logic [NUM_CS-1:0]          hold_q;
    logic                       active, done, rx_we;
    logic [DSEL_W-1:0]          rx_idx;
    logic [7:0]                 rx_byte;

    sfl_uma_regs #(
        .ADDR_BYTES(ADDR_BYTES), .DATA_BYTES(DATA_BYTES), .NUM_CS(NUM_CS), .DSEL_W(DSEL_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done(done),
        .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte),
        .opcode_q(opcode_q), .addr_q(addr_q), .data_q(data_q),
        .ctrl_q(ctrl_q), .hold_q(hold_q)
    );

    sfl_uma_seq #(
        .ADDR_BYTES(ADDR_BYTES), .DATA_BYTES(DATA_BYTES), .DSEL_W(DSEL_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .busy(ctrl_q.go), .cnt(ctrl_q.cnt),
        .aen(ctrl_q.aen), .wr(ctrl_q.wr), .opcode_q(opcode_q), .addr_q(addr_q),
        .data_q(data_q), .spi_miso(spi_miso), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .active(active), .done(done), .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte)
    );

    sfl_uma_csel #(
        .NUM_CS(NUM_CS), .SEL_W(SEL_W)
    ) u_csel (
        .clk(clk), .rst_n(rst_n), .active(active), .sel(ctrl_q.sel),
        .hold_q(hold_q), .spi_cs_n(spi_cs_n)
    );

    // R8: the chosen select is low for the whole transaction.
    p_sel_low_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> !spi_cs_n[ctrl_q.sel]);

    // R9: a cleared hold bit keeps its select low.
    p_hold_keeps_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_q[0] && $past(!hold_q[0])) |-> !spi_cs_n[0]);

endmodule

// File: tb/sfl_uma_engine_bench.sv
module sfl_uma_engine_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = 4'h0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       spi_sck, spi_mosi;
    logic [3:0] spi_cs_n;

    int n_total = 0;
    int n_fail  = 0;

    // flash model state
    logic [63:0] slv_rx = '0;
    logic [63:0] slv_tx = '0;
    logic [63:0] slv_load = '0;
    logic [7:0]  slv_bits = '0;
    logic        slv_sck_q = 1'b0;
    logic        slv_clr = 1'b0;
    logic        spi_miso;

    always #10 clk = ~clk;

    sfl_uma_engine u_sfl_uma_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    // Flash model: samples MOSI after each rising SCK, advances MISO at the same time.
    always @(negedge clk) begin
        if (slv_clr) begin
            slv_rx   <= '0;
            slv_bits <= '0;
            slv_tx   <= slv_load;
        end else if (spi_sck && !slv_sck_q) begin
            slv_rx   <= {slv_rx[62:0], spi_mosi};
            slv_tx   <= {slv_tx[62:0], 1'b0};
            slv_bits <= slv_bits + 8'd1;
        end
        slv_sck_q <= spi_sck;
    end
    assign spi_miso = slv_tx[63];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic int eff_cnt(input logic [7:0] c);
        return (c[2:0] > 3'd4) ? 4 : int'(c[2:0]);
    endfunction

    function automatic int n_bytes(input logic [7:0] c);
        return 1 + (c[3] ? 3 : 0) + eff_cnt(c);
    endfunction

    // Expected MOSI stream, last byte in the low bits (R4, R5, R6).
    function automatic logic [63:0] exp_mosi(input logic [7:0] c, input logic [7:0] op,
                                             input logic [23:0] ad, input logic [31:0] wd);
        logic [63:0] e;
        e = 64'(op);
        if (c[3]) begin
            e = {e[55:0], ad[23:16]};
            e = {e[55:0], ad[15:8]};
            e = {e[55:0], ad[7:0]};
        end
        for (int j = 0; j < eff_cnt(c); j++)
            e = {e[55:0], (c[4] ? wd[8*j +: 8] : 8'h00)};
        return e;
    endfunction

    task automatic run_txn(input logic [7:0] c, input logic [7:0] op, input logic [23:0] ad,
                           input logic [31:0] wd, input logic [31:0] resp, input logic [31:0] exp_data,
                           input logic [3:0] hold);
        int k;
        int nb;
        int pre;
        logic [7:0]  rb;
        logic [31:0] got;
        logic [63:0] ld;
        logic [3:0]  cs_busy, cs_idle;
        nb  = n_bytes(c);
        pre = 1 + (c[3] ? 3 : 0);
        ld  = '0;
        for (int j = 0; j < eff_cnt(c); j++)
            ld[63 - 8*(pre + j) -: 8] = resp[8*j +: 8];
        reg_write(4'h0, op);
        reg_write(4'h1, ad[7:0]);
        reg_write(4'h2, ad[15:8]);
        reg_write(4'h3, ad[23:16]);
        for (int j = 0; j < 4; j++)
            reg_write(4'(4 + j), wd[8*j +: 8]);
        @(posedge clk); slv_load = ld; slv_clr = 1'b1;
        @(posedge clk); slv_clr = 1'b0;
        cs_busy = ~(4'(1 << c[6:5]) | ~hold);
        cs_idle = hold;
        reg_write(4'h8, c);
        k = 0;
        #1;
        while (reg_rdata[7] && k < 1000) begin
            @(posedge clk); k++;
            @(negedge clk); #1;
            if (k == 5)
                check(spi_cs_n == cs_busy, "R8 select during transfer", 64'(spi_cs_n), 64'(cs_busy));
        end
        check(k == 16*nb + 3, "R2 busy clear cycle", 64'(k), 64'(16*nb + 3));
        check(spi_cs_n == cs_idle, "R9 select level after transfer", 64'(spi_cs_n), 64'(cs_idle));
        check(slv_bits == 8'(8*nb), "R11 rising SCK count", 64'(slv_bits), 64'(8*nb));
        check(slv_rx == exp_mosi(c, op, ad, wd), "R4 MOSI stream", slv_rx, exp_mosi(c, op, ad, wd));
        reg_read(4'h8, rb);
        check(rb == (c & 8'h7F), "R3 control readback", 64'(rb), 64'(c & 8'h7F));
        for (int j = 0; j < 4; j++) begin
            reg_read(4'(4 + j), rb);
            got[8*j +: 8] = rb;
        end
        check(got == exp_data, c[4] ? "R5 data kept" : "R6 data captured", 64'(got), 64'(exp_data));
    endtask

    // ctrl, cmd, addr, write data, MISO bytes, expected data regs
    localparam logic [135:0] VEC [6] = '{
        {8'h80, 8'h06, 24'h000000, 32'h01020304, 32'h00000000, 32'h01020304},
        {8'hBA, 8'h02, 24'h123456, 32'hA1B2C3D4, 32'h00000000, 32'hA1B2C3D4},
        {8'hCC, 8'h03, 24'hABCDEF, 32'h11223344, 32'h5AA5F00F, 32'h5AA5F00F},
        {8'hE3, 8'h9F, 24'h000000, 32'hCAFEBABE, 32'h00C22017, 32'hCAC22017},
        {8'h8F, 8'h0B, 24'h000100, 32'h00000000, 32'h87654321, 32'h87654321},
        {8'hD1, 8'h01, 24'h000000, 32'h000000F0, 32'h00000000, 32'h000000F0}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        logic [7:0] rb;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        reg_read(4'h8, rb);
        check(rb == 8'h00, "R1 control reset", 64'(rb), 64'h00);
        reg_read(4'h9, rb);
        check(rb == 8'h0F, "R1 hold reset", 64'(rb), 64'h0F);
        check(spi_cs_n == 4'hF, "R1 selects high", 64'(spi_cs_n), 64'hF);
        check(spi_sck == 1'b0, "R1 SCK low", 64'(spi_sck), 64'h0);

        // Table: R2..R8, R11; row 4 uses count 7 (R7)
        foreach (VEC[i])
            run_txn(VEC[i][135:128], VEC[i][127:120], VEC[i][119:96], VEC[i][95:64],
                    VEC[i][63:32], VEC[i][31:0], 4'hF);

        // R9: hold select 0 low across two transactions on select 0
        reg_write(4'h9, 8'h0E);
        check(spi_cs_n == 4'hE, "R9 hold asserts idle select", 64'(spi_cs_n), 64'hE);
        run_txn(8'h82, 8'h05, 24'h0, 32'h0, 32'h0000A55A, 32'h0000A55A, 4'hE);
        run_txn(8'h81, 8'h00, 24'h0, 32'h0, 32'h000000C3, 32'h000000C3, 4'hE);
        reg_write(4'h9, 8'h0F);
        check(spi_cs_n == 4'hF, "R9 hold release", 64'(spi_cs_n), 64'hF);

        // R9: hold on select 2 while transacting on select 1
        reg_write(4'h9, 8'h0B);
        run_txn(8'hB0, 8'h06, 24'h0, 32'h0, 32'h0, 32'h0, 4'hB);
        reg_write(4'h9, 8'h0F);

        // R10: writes while busy are ignored
        reg_write(4'h0, 8'h66);
        reg_write(4'h4, 8'h77);
        reg_write(4'h8, 8'h90);
        reg_write(4'h0, 8'h55);
        reg_write(4'h4, 8'h11);
        reg_write(4'h9, 8'h00);
        reg_write(4'h8, 8'hE4);
        reg_addr = 4'h8;
        repeat (60) @(posedge clk);
        reg_read(4'h0, rb);
        check(rb == 8'h66, "R10 command locked", 64'(rb), 64'h66);
        reg_read(4'h4, rb);
        check(rb == 8'h77, "R10 data locked", 64'(rb), 64'h77);
        reg_read(4'h9, rb);
        check(rb == 8'h0F, "R10 hold locked", 64'(rb), 64'h0F);
        reg_read(4'h8, rb);
        check(rb == 8'h10, "R10 control locked", 64'(rb), 64'h10);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule